// File: doc/BRIEF.md
# Signed Multiplier with Overflow Flags

This execution unit multiplies two's-complement integers at an operand size of 8, 16, 32 or 64 bits. It has three result forms. The widening form returns the full double-width product, split into a low half and a high half. The truncating form multiplies a destination operand by a source operand and keeps only the low operand-size bits. The immediate form multiplies a source operand by an immediate and also keeps only the low operand-size bits.

A carry flag and an overflow flag are produced, and the two always agree. They are raised when the product has significant bits beyond the width that is kept. The detection compares the full product with the sign extension of the part that is kept. The sign, zero, auxiliary-carry and parity flags carry no meaning for this operation, so they are driven low.

The unit is fully pipelined with a single register stage. A request presented with `valid_i` in one cycle produces its result, its flags and `done_o` in the next cycle. A new request may be issued in every cycle.

Top module: `smul_unit`

## Requirements
- R1: `done_o` is high exactly in the cycle after a cycle with `valid_i` high, so a request may be issued every cycle. When `valid_i` is low, `done_o` falls, and the result and flag outputs keep their previous values.
- R2: `size_i` encodes 0 as 8 bits, 1 as 16, 2 as 32 and 3 as 64. Operands are read as signed values from the low operand-size bits of `opa_i`, `opb_i` and `imm_i`, and any higher input bits are ignored.
- R3: In the widening form (`form_i`=0) at 8 bits, `res_lo_o[15:0]` holds the whole 16-bit product of `opa_i` and `opb_i`. All other bits of `res_lo_o` are zero, and `res_hi_o` is zero.
- R4: In the widening form at 16, 32 or 64 bits, `res_lo_o` holds the low operand-size bits of the product and `res_hi_o` holds the next operand-size bits. Both are zero-extended to 64 bits.
- R5: In the widening form, `cf_o` and `of_o` are 1 when the product differs from the sign extension of its low operand-size bits, and 0 otherwise.
- R6: In the truncating form (`form_i`=1), `res_lo_o` is the low operand-size bits of `opa_i`×`opb_i`, zero-extended, and `res_hi_o` is zero.
- R7: In the immediate form (`form_i`=2), `res_lo_o` is the low operand-size bits of `opb_i`×immediate, zero-extended, and `res_hi_o` is zero.
- R8: In the truncating and immediate forms, `cf_o` and `of_o` are 1 exactly when the sign-extended kept result differs from the full product. This holds for the most negative value times −1 at every size, while −1 times −1 gives 0.
- R9: With `imm_byte_i`=1, `imm_i[7:0]` is sign-extended to the operand size. With `imm_byte_i`=0, the immediate is `imm_i` at the operand size, except at 64 bits, where `imm_i[31:0]` is sign-extended to 64 bits.
- R10: `cf_o` always equals `of_o`. `sf_o`, `zf_o`, `af_o` and `pf_o` are always 0.
- R11: While `rst_ni` is low, all outputs are zero.
- R12: The unused form code 3 behaves exactly like the truncating form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| size_i | input | 2 | Operand size code |
| form_i | input | 2 | Result form code |
| opa_i | input | 64 | Destination or accumulator operand |
| opb_i | input | 64 | Source operand |
| imm_i | input | 32 | Immediate value |
| imm_byte_i | input | 1 | Immediate is 8 bits wide |
| res_lo_o | output | 64 | Low result half, zero-extended |
| res_hi_o | output | 64 | High result half, zero-extended |
| cf_o | output | 1 | Carry flag |
| of_o | output | 1 | Overflow flag |
| sf_o | output | 1 | Sign flag, driven 0 |
| zf_o | output | 1 | Zero flag, driven 0 |
| af_o | output | 1 | Auxiliary-carry flag, driven 0 |
| pf_o | output | 1 | Parity flag, driven 0 |
| done_o | output | 1 | Result strobe |

## Verification
Only one register stage sits between a request and its result, so any fault in operand selection, sign extension, placement or overflow detection appears at the outputs in the very next cycle and is tied to a single request. A size or sign-extension fault changes `res_lo_o` or `res_hi_o` only for operands whose upper bits are nonzero or negative. For that reason the stimulus puts random bits above the operand width. An error in the window of the overflow detector shows up only near the boundary, so the most negative value times −1 and −1 times −1 are driven at every size and in every form.

// File: rtl/smul_pkg.sv
package smul_pkg;
  parameter int unsigned XLEN  = 64;
  parameter int unsigned IMM_W = 32;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    FM_WIDE  = 2'd0,
    FM_TRUNC = 2'd1,
    FM_IMM   = 2'd2,
    FM_RSVD  = 2'd3
  } form_e;
endpackage

// File: rtl/smul_opsel.sv
module smul_opsel
  import smul_pkg::*;
#(
  parameter int unsigned W_MAX = XLEN,
  parameter int unsigned W_IMM = IMM_W
) (
  input  size_e              size_i,
  input  form_e              form_i,
  input  logic [W_MAX-1:0]   opa_i,
  input  logic [W_MAX-1:0]   opb_i,
  input  logic [W_IMM-1:0]   imm_i,
  input  logic               imm_byte_i,
  output logic [W_MAX-1:0]   mul_a_o,
  output logic [W_MAX-1:0]   mul_b_o
);
  localparam int unsigned NSZ = $clog2(W_MAX / 8) + 1;

  logic [W_MAX-1:0] imm_full;
  logic [W_MAX-1:0] ext_a [NSZ];
  logic [W_MAX-1:0] ext_b [NSZ];
  logic [W_MAX-1:0] ext_i [NSZ];

  // immediate widened from its encoded width first, then narrowed to operand size
  always_comb begin
    if (imm_byte_i) imm_full = {{(W_MAX-8){imm_i[7]}}, imm_i[7:0]};
    else            imm_full = {{(W_MAX-W_IMM){imm_i[W_IMM-1]}}, imm_i};
  end

  for (genvar k = 0; k < NSZ; k++) begin : g_ext
    localparam int unsigned W = 8 << k;
    if (W == W_MAX) begin : g_full
      assign ext_a[k] = opa_i;
      assign ext_b[k] = opb_i;
      assign ext_i[k] = imm_full;
    end else begin : g_part
      assign ext_a[k] = {{(W_MAX-W){opa_i[W-1]}},    opa_i[W-1:0]};
      assign ext_b[k] = {{(W_MAX-W){opb_i[W-1]}},    opb_i[W-1:0]};
      assign ext_i[k] = {{(W_MAX-W){imm_full[W-1]}}, imm_full[W-1:0]};
    end
  end

  always_comb begin
    if (form_i == FM_IMM) begin
      mul_a_o = ext_b[size_i];
      mul_b_o = ext_i[size_i];
    end else begin
      mul_a_o = ext_a[size_i];
      mul_b_o = ext_b[size_i];
    end
  end
endmodule

// File: rtl/smul_core.sv
module smul_core
  import smul_pkg::*;
#(
  parameter int unsigned W_MAX = XLEN
) (
  input  size_e              size_i,
  input  logic [W_MAX-1:0]   mul_a_i,
  input  logic [W_MAX-1:0]   mul_b_i,
  output logic [2*W_MAX-1:0] prod_o,
  output logic               ovf_o
);
  localparam int unsigned NSZ = $clog2(W_MAX / 8) + 1;
  localparam int unsigned PW  = 2 * W_MAX;

  logic [NSZ-1:0] ovf_v;

  assign prod_o = $signed({{W_MAX{mul_a_i[W_MAX-1]}}, mul_a_i})
                * $signed({{W_MAX{mul_b_i[W_MAX-1]}}, mul_b_i});

  // product fits in W bits when bits [PW-1:W-1] are all copies of one sign
  for (genvar k = 0; k < NSZ; k++) begin : g_ovf
    localparam int unsigned W = 8 << k;
    logic [PW-W:0] upper;
    assign upper    = prod_o[PW-1:W-1];
    assign ovf_v[k] = ~((&upper) | (~|upper));
  end

  assign ovf_o = ovf_v[size_i];
endmodule

// File: rtl/smul_place.sv
module smul_place
  import smul_pkg::*;
#(
  parameter int unsigned W_MAX = XLEN
) (
  input  size_e              size_i,
  input  form_e              form_i,
  input  logic [2*W_MAX-1:0] prod_i,
  output logic [W_MAX-1:0]   lo_o,
  output logic [W_MAX-1:0]   hi_o
);
  localparam int unsigned NSZ = $clog2(W_MAX / 8) + 1;

  logic [W_MAX-1:0] lo_v [NSZ];
  logic [W_MAX-1:0] hi_v [NSZ];
  logic [W_MAX-1:0] lo_b_wide;

  for (genvar k = 0; k < NSZ; k++) begin : g_slice
    localparam int unsigned W = 8 << k;
    assign lo_v[k] = W_MAX'(prod_i[W-1:0]);
    assign hi_v[k] = W_MAX'(prod_i[2*W-1:W]);
  end

  // 8-bit widening result lands whole in one 16-bit destination
  assign lo_b_wide = W_MAX'(prod_i[15:0]);

  always_comb begin
    lo_o = lo_v[size_i];
    hi_o = '0;
    if (form_i == FM_WIDE) begin
      if (size_i == SZ_B) lo_o = lo_b_wide;
      else                hi_o = hi_v[size_i];
    end
  end
endmodule

// File: rtl/smul_unit.sv
module smul_unit
  import smul_pkg::*;
#(
  parameter int unsigned W_MAX = XLEN,
  parameter int unsigned W_IMM = IMM_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [1:0]         size_i,
  input  logic [1:0]         form_i,
  input  logic [W_MAX-1:0]   opa_i,
  input  logic [W_MAX-1:0]   opb_i,
  input  logic [W_IMM-1:0]   imm_i,
  input  logic               imm_byte_i,
  output logic [W_MAX-1:0]   res_lo_o,
  output logic [W_MAX-1:0]   res_hi_o,
  output logic               cf_o,
  output logic               of_o,
  output logic               sf_o,
  output logic               zf_o,
  output logic               af_o,
  output logic               pf_o,
  output logic               done_o
);
  size_e              size;
  form_e              form;
  logic [W_MAX-1:0]   mul_a, mul_b;
  logic [2*W_MAX-1:0] prod;
  logic               ovf;
  logic [W_MAX-1:0]   lo_d, hi_d;

  logic [W_MAX-1:0]   lo_q, hi_q;
  logic               cf_q, of_q, done_q;

  assign size = size_e'(size_i);
  assign form = form_e'(form_i);

  smul_opsel #(.W_MAX(W_MAX), .W_IMM(W_IMM)) u_opsel (
    .size_i    (size),
    .form_i    (form),
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .imm_i     (imm_i),
    .imm_byte_i(imm_byte_i),
    .mul_a_o   (mul_a),
    .mul_b_o   (mul_b)
  );

  smul_core #(.W_MAX(W_MAX)) u_core (
    .size_i (size),
    .mul_a_i(mul_a),
    .mul_b_i(mul_b),
    .prod_o (prod),
    .ovf_o  (ovf)
  );

  smul_place #(.W_MAX(W_MAX)) u_place (
    .size_i(size),
    .form_i(form),
    .prod_i(prod),
    .lo_o  (lo_d),
    .hi_o  (hi_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      hi_q   <= '0;
      cf_q   <= 1'b0;
      of_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= valid_i;
      if (valid_i) begin
        lo_q <= lo_d;
        hi_q <= hi_d;
        cf_q <= ovf;
        of_q <= ovf;
      end
    end
  end

  assign res_lo_o = lo_q;
  assign res_hi_o = hi_q;
  assign cf_o     = cf_q;
  assign of_o     = of_q;
  assign done_o   = done_q;
  assign sf_o     = 1'b0;
  assign zf_o     = 1'b0;
  assign af_o     = 1'b0;
  assign pf_o     = 1'b0;

  assert_done_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);

  assert_idle_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o && $stable(res_lo_o) && $stable(res_hi_o) && $stable(cf_o));

  assert_trunc_hi_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && form_i != FM_WIDE |=> res_hi_o == '0);

  assert_byte_zero_ext_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && size_i == SZ_B && form_i != FM_WIDE |=> res_lo_o[W_MAX-1:8] == '0);

  assert_wide_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && form_i == FM_WIDE && size_i == SZ_D
      |=> cf_o == (res_hi_o != {W_MAX{res_lo_o[W_MAX-1]}}));

  assert_flags_agree_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cf_o == of_o);
endmodule

// File: tb/sim_smul_unit.sv
`timescale 1ns/1ps
module sim_smul_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  size_i = '0;
  logic [1:0]  form_i = '0;
  logic [63:0] opa_i = '0, opb_i = '0;
  logic [31:0] imm_i = '0;
  logic        imm_byte_i = 1'b0;
  logic [63:0] res_lo_o, res_hi_o;
  logic        cf_o, of_o, sf_o, zf_o, af_o, pf_o, done_o;

  int checks = 0;
  int fails  = 0;

  logic        pend = 1'b0;
  logic        e_done = 1'b0, e_f = 1'b0;
  logic [63:0] e_lo = '0, e_hi = '0;
  string       e_tag = "R11";

  always #2.5 clk_i = ~clk_i;

  smul_unit u0 (
    .clk_i, .rst_ni, .valid_i, .size_i, .form_i, .opa_i, .opb_i, .imm_i,
    .imm_byte_i, .res_lo_o, .res_hi_o, .cf_o, .of_o, .sf_o, .zf_o, .af_o,
    .pf_o, .done_o
  );

  function automatic logic [63:0] sx(logic [63:0] v, int w);
    logic signed [63:0] t;
    t = $signed(v << (64 - w));
    return t >>> (64 - w);
  endfunction

  function automatic logic [63:0] msk(int w);
    return (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction

  task automatic model(input logic [1:0] sz, input logic [1:0] fm,
                       input logic [63:0] a, input logic [63:0] b,
                       input logic [31:0] im, input logic ib,
                       output logic [63:0] lo, output logic [63:0] hi,
                       output logic f);
    int w;
    logic [63:0] x, y, lowx;
    logic signed [127:0] p, lx;
    w = 8 << sz;
    if (fm == 2'd2) begin
      x = sx(b, w);
      y = ib ? sx({56'b0, im[7:0]}, 8) : sx({32'b0, im}, 32);
      y = sx(y, w);
    end else begin
      x = sx(a, w);
      y = sx(b, w);
    end
    p = $signed({{64{x[63]}}, x}) * $signed({{64{y[63]}}, y});
    lowx = sx(p[63:0], w);
    lx = $signed({{64{lowx[63]}}, lowx});
    f = (p != lx);
    if (fm == 2'd0) begin
      if (w == 8) begin lo = {48'b0, p[15:0]}; hi = '0; end
      else begin lo = p[63:0] & msk(w); hi = p[127:64] & msk(w); hi = (w == 64) ? p[127:64] : (p[63:0] >> w) & msk(w); end
    end else begin
      lo = p[63:0] & msk(w);
      hi = '0;
    end
  endtask

  task automatic check_out();
    checks++;
    if (done_o !== e_done || res_lo_o !== e_lo || res_hi_o !== e_hi ||
        cf_o !== e_f || of_o !== e_f || {sf_o, zf_o, af_o, pf_o} !== 4'b0) begin
      fails++;
      $display("FAIL %s R10: actual done=%0b lo=%h hi=%h cf=%0b of=%0b sz_af_p=%b%b%b%b expected done=%0b lo=%h hi=%h cf=of=%0b undef=0000",
               e_tag, done_o, res_lo_o, res_hi_o, cf_o, of_o, sf_o, zf_o, af_o, pf_o,
               e_done, e_lo, e_hi, e_f);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] sz, input logic [1:0] fm,
                       input logic [63:0] a, input logic [63:0] b,
                       input logic [31:0] im, input logic ib, input string tag);
    @(negedge clk_i);
    if (pend) check_out();
    valid_i = v; size_i = sz; form_i = fm; opa_i = a; opb_i = b;
    imm_i = im; imm_byte_i = ib;
    if (v) begin
      model(sz, fm, a, b, im, ib, e_lo, e_hi, e_f);
      e_tag = tag;
    end else e_tag = "R1 hold";
    e_done = v;
    pend = 1'b1;
  endtask

  function automatic logic [63:0] pick();
    case ($urandom % 7)
      0: return '0;
      1: return '1;
      2: return 64'h8000_0000_0000_0000 >> (8 * ($urandom % 8));
      3: return {$urandom, $urandom} | 64'hFFFF_FFFF_FFFF_FF80;
      4: return 64'h7FFF_FFFF_FFFF_FFFF >> (8 * ($urandom % 8));
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk_i);
    // R11: reset state
    checks++;
    if ({res_lo_o, res_hi_o, cf_o, of_o, sf_o, zf_o, af_o, pf_o, done_o} !== '0) begin
      fails++;
      $display("FAIL R11: actual lo=%h hi=%h done=%0b expected all zero", res_lo_o, res_hi_o, done_o);
    end
    rst_ni = 1'b1;

    for (int s = 0; s < 4; s++) begin
      int w;
      logic [63:0] mn;
      w = 8 << s;
      mn = 64'h8000_0000_0000_0000 >> (64 - w);
      // R13-style corners: min * -1 overflows, -1 * -1 does not (R5 R8)
      drive(1, s[1:0], 2'd0, mn | ~msk(w) & 64'hA5A5_A5A5_A5A5_A5A5, '1, '0, 0, "R3 R4 R5 min*-1");
      drive(1, s[1:0], 2'd1, mn, '1, '0, 0, "R6 R8 min*-1");
      drive(1, s[1:0], 2'd0, '1, '1, '0, 0, "R5 -1*-1");
      drive(1, s[1:0], 2'd1, '1, msk(w), '0, 0, "R8 -1*-1");
      drive(1, s[1:0], 2'd2, '0, mn, 32'hFF, 1, "R7 R9 min*imm8(-1)");
      drive(1, s[1:0], 2'd2, '0, mn, 32'hFFFF_FFFF, 0, "R7 R9 min*imm(-1)");
      drive(1, s[1:0], 2'd3, mn, '1, '0, 0, "R12 reserved form");
      drive(1, s[1:0], 2'd1, {32'hDEAD_BEEF, 32'h0000_0003}, {32'h1234_5678, 32'hFFFF_FFFE}, '0, 0, "R2 upper bits ignored");
    end
    // R9: 64-bit immediate sign-extended from 32 bits
    drive(1, 2'd3, 2'd2, '0, 64'd2, 32'h8000_0000, 0, "R9 imm32 sext64");
    drive(1, 2'd3, 2'd2, '0, 64'd3, 32'h0000_0080, 1, "R9 imm8 sext64");
    // R1: idle cycles hold results and drop done
    drive(0, 2'd0, 2'd0, '1, '1, '0, 0, "R1");
    drive(0, 2'd3, 2'd1, 64'd7, 64'd9, '0, 0, "R1");

    for (int i = 0; i < 3000; i++) begin
      logic [1:0] fm;
      fm = 2'($urandom % 4);
      drive(($urandom % 5) != 0, 2'($urandom % 4), fm, pick(), pick(),
            $urandom, 1'($urandom % 2),
            fm == 2'd0 ? "R3 R4 R5 random" : fm == 2'd2 ? "R7 R8 R9 random" :
            fm == 2'd3 ? "R12 random" : "R6 R8 random");
    end
    drive(0, 2'd0, 2'd0, '0, '0, '0, 0, "R1");
    @(negedge clk_i);
    check_out();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule